// File: doc/BRIEF.md
# Serial NAND Feature Register Responder

This block is the device side of a single-lane SPI link (mode 0: clock idles low, data sampled on the rising edge) that models the feature registers of a serial NAND memory. The host reaches three registers through a one-byte register address: a block-protection register, a configuration register and a status register. It can also set or clear a write-enable latch. The SPI pins are sampled by the fast system clock through a synchronizer, so the SPI clock must run several times slower than the system clock.

An internal array model, which is not part of this block, drives a side port that loads the busy, erase-fail, program-fail and ECC result fields of the status register. The host cannot write these fields. The current block-protection and configuration values and the write-enable latch are brought out as plain outputs so that the array model can act on them. Page storage and multi-lane transfers are outside this block.

Top module: `nand_feat_resp`

## Requirements
- R1: A read-register command is the opcode 0x0F, then one address byte, then one data byte returned with no dummy cycles. The data is shifted out MSB first, changing on falling SCLK edges. `spi_miso` is 0 whenever chip select is high or no data is being returned.
- R2: A write-register command is the opcode 0x1F, then one address byte, then one data byte. To address 0xA0 (block protection) it stores all 8 bits. To address 0xB0 (configuration) it stores only bit 6 (OTP access), bit 4 (on-die ECC) and bit 0 (quad), and the other bits read 0. `blk_lock` and `cfg_bits` show the stored values.
- R3: Address 0xC0 reads the status register. Bit 0 is busy, bit 1 is the write-enable latch, bit 2 is erase failed, bit 3 is program failed, bits 5:4 are the ECC result (00 no bit flips, 01 corrected, 10 uncorrectable) and bits 7:6 are 0. A host write to 0xC0 changes nothing.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Either takes effect at chip-select deassertion, and only if exactly 8 bits were clocked in that frame. `wr_enabled` shows the latch.
- R5: A one-cycle pulse on `ar_upd` loads `ar_busy`, `ar_erase_fail`, `ar_prog_fail` and `ar_ecc` into status bits 0, 2, 3 and 5:4.
- R6: A read of any address other than 0xA0, 0xB0 or 0xC0 returns 0x00. An unrecognised opcode changes no register for the rest of its frame.
- R7: If chip select is deasserted partway through a byte, the command in progress is cancelled: a partly received write data byte is not stored.
- R8: After a synchronous active-low reset, block protection reads 0x38, configuration reads 0x10, status reads 0x00 and the write-enable latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the host, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| ar_upd | input | 1 | Status-load strobe from the array model |
| ar_busy | input | 1 | Busy value to load |
| ar_erase_fail | input | 1 | Erase-failed value to load |
| ar_prog_fail | input | 1 | Program-failed value to load |
| ar_ecc | input | 2 | ECC result code to load |
| blk_lock | output | 8 | Current block-protection value |
| cfg_bits | output | 8 | Current configuration value |
| wr_enabled | output | 1 | Write-enable latch |

## Verification
The hardest case to reach from the ports is a frame that ends at a bad point. Examples are a write data byte cut off after a few bits, and a write-enable opcode followed by stray clocks before chip select rises. In both cases the engine reaches the commit point with a byte counter that is not zero. The bench drives such frames by clocking a chosen number of bits and then raising chip select mid-byte. It then reads the target register back with a complete frame and also checks the mirror outputs, to show that nothing was committed.

// File: rtl/nfr_pkg.sv
// Package: opcodes, register addresses, field masks and reset values shared
// by the feature register responder. Assumes 8-bit opcode/address/data bytes.
package nfr_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_GET   = 8'h0F;
    localparam logic [BYTE_W-1:0] OP_SET   = 8'h1F;
    localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WRDIS = 8'h04;

    localparam logic [BYTE_W-1:0] ADR_LOCK = 8'hA0;
    localparam logic [BYTE_W-1:0] ADR_CFG  = 8'hB0;
    localparam logic [BYTE_W-1:0] ADR_STAT = 8'hC0;

    // Writable configuration bits: OTP access (6), on-die ECC (4), quad (0)
    localparam logic [BYTE_W-1:0] CFG_MASK = 8'h51;

    localparam logic [BYTE_W-1:0] LOCK_RST = 8'h38;
    localparam logic [BYTE_W-1:0] CFG_RST  = 8'h10;

    // Frame position of the command decoder
    typedef enum logic [2:0] {
        FR_OPCODE,
        FR_ADDR,
        FR_WDATA,
        FR_SINGLE,
        FR_DRAIN
    } frame_t;
endpackage

// File: rtl/nfr_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes each pin changes slowly relative to clk (no bus coherence needed).
module nfr_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the pins through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/nfr_byte_rx.sv
// SPI mode-0 edge detector and byte deserializer working on synchronized pins.
// Reports falling SCLK edges, a byte-complete strobe one cycle after the 8th
// rising edge, chip-select rise, and whether the bit counter sits on a byte
// boundary. Assumes SCLK is at least 4 clk periods per phase.
module nfr_byte_rx #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    output logic              sck_fall_o,
    output logic              byte_done_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              aligned_o,
    output logic              cs_rise_o,
    output logic              cs_hi_o
);
    logic              sck_d, cs_d, sck_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;

    assign sck_rise   = sck_s & ~sck_d & ~cs_n_s;
    assign sck_fall_o = ~sck_s & sck_d & ~cs_n_s;
    assign cs_rise_o  = cs_n_s & ~cs_d;
    assign cs_hi_o    = cs_n_s;
    assign aligned_o  = (bit_cnt == '0);

    // Previous pin levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    // Shift MOSI in on rising edges and flag completed bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            shreg       <= '0;
            byte_o      <= '0;
            byte_done_o <= 1'b0;
        end else begin
            byte_done_o <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[BYTE_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                    byte_o      <= {shreg[BYTE_W-2:0], mosi_s};
                    byte_done_o <= 1'b1;
                end
            end
        end
    end

    // R7: a deselected bus always leaves the counter on a byte boundary
    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> aligned_o);
endmodule

// File: rtl/nfr_regs.sv
// Feature register file: block protection, masked configuration, status
// fields loaded by the array model, and the write-enable latch.
// Assumes at most one host write per cycle; status fields are never host-written.
module nfr_regs
    import nfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [BYTE_W-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              upd_i,
    input  logic              upd_busy_i,
    input  logic              upd_efail_i,
    input  logic              upd_pfail_i,
    input  logic [1:0]        upd_ecc_i,
    output logic [BYTE_W-1:0] lock_o,
    output logic [BYTE_W-1:0] cfg_o,
    output logic              wel_o
);
    logic       busy_q, efail_q, pfail_q;
    logic [1:0] ecc_q;

    // Host-writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_o <= LOCK_RST;
            cfg_o  <= CFG_RST;
        end else if (wr_i) begin
            if (wr_addr_i == ADR_LOCK) lock_o <= wr_data_i;
            if (wr_addr_i == ADR_CFG)  cfg_o  <= wr_data_i & CFG_MASK;
        end
    end

    // Status fields owned by the array model
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            efail_q <= 1'b0;
            pfail_q <= 1'b0;
            ecc_q   <= 2'b00;
        end else if (upd_i) begin
            busy_q  <= upd_busy_i;
            efail_q <= upd_efail_i;
            pfail_q <= upd_pfail_i;
            ecc_q   <= upd_ecc_i;
        end
    end

    // Write-enable latch
    always_ff @(posedge clk) begin
        if (!rst_n)         wel_o <= 1'b0;
        else if (wel_set_i) wel_o <= 1'b1;
        else if (wel_clr_i) wel_o <= 1'b0;
    end

    // Register read mux; unknown addresses read zero
    always_comb begin
        case (rd_addr_i)
            ADR_LOCK: rd_data_o = lock_o;
            ADR_CFG:  rd_data_o = cfg_o;
            ADR_STAT: rd_data_o = {2'b00, ecc_q, pfail_q, efail_q, wel_o, busy_q};
            default:  rd_data_o = '0;
        endcase
    end

    // R3: status fields move only on an array-model load
    p_stat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable({busy_q, efail_q, pfail_q, ecc_q}));
    // R2: a configuration write keeps only the defined bits
    p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wr_addr_i == ADR_CFG) |=> cfg_o == ($past(wr_data_i) & CFG_MASK));
    // R4: the latch moves only on a write-enable or write-disable strobe
    p_wel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wel_set_i && !wel_clr_i) |=> $stable(wel_o));
endmodule

// File: rtl/nand_feat_resp.sv
// Top: SPI mode-0 responder for serial NAND feature registers. Decodes the
// read-register, write-register, write-enable and write-disable commands,
// and serializes read data MSB first on falling SCLK edges.
// Assumes the SCLK phases are each at least 4 clk periods long.
module nand_feat_resp
    import nfr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              ar_upd,
    input  logic              ar_busy,
    input  logic              ar_erase_fail,
    input  logic              ar_prog_fail,
    input  logic [1:0]        ar_ecc,
    output logic [BYTE_W-1:0] blk_lock,
    output logic [BYTE_W-1:0] cfg_bits,
    output logic              wr_enabled
);
    localparam int TXC_W = $clog2(BYTE_W + 1);

    logic              sck_s, cs_n_s, mosi_s;
    logic              sck_fall, byte_done, aligned, cs_rise, cs_hi;
    logic [BYTE_W-1:0] rx_byte, op_q, addr_q, rd_data;
    logic [BYTE_W-1:0] tx_sr;
    logic [TXC_W-1:0]  tx_left;
    logic              reg_wr, wel_set, wel_clr;
    frame_t            frame_q;

    nfr_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spi_sck, spi_cs_n, spi_mosi}),
        .q_o   ({sck_s, cs_n_s, mosi_s})
    );

    nfr_byte_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_s       (sck_s),
        .cs_n_s      (cs_n_s),
        .mosi_s      (mosi_s),
        .sck_fall_o  (sck_fall),
        .byte_done_o (byte_done),
        .byte_o      (rx_byte),
        .aligned_o   (aligned),
        .cs_rise_o   (cs_rise),
        .cs_hi_o     (cs_hi)
    );

    // Host write fires when the data byte of a write-register command lands
    assign reg_wr  = byte_done && (frame_q == FR_WDATA);
    // Single-byte commands commit at deselect, only on a clean byte boundary
    assign wel_set = cs_rise && aligned && (frame_q == FR_SINGLE) && (op_q == OP_WREN);
    assign wel_clr = cs_rise && aligned && (frame_q == FR_SINGLE) && (op_q == OP_WRDIS);

    nfr_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (reg_wr),
        .wr_addr_i   (addr_q),
        .wr_data_i   (rx_byte),
        .rd_addr_i   (rx_byte),
        .rd_data_o   (rd_data),
        .wel_set_i   (wel_set),
        .wel_clr_i   (wel_clr),
        .upd_i       (ar_upd),
        .upd_busy_i  (ar_busy),
        .upd_efail_i (ar_erase_fail),
        .upd_pfail_i (ar_prog_fail),
        .upd_ecc_i   (ar_ecc),
        .lock_o      (blk_lock),
        .cfg_o       (cfg_bits),
        .wel_o       (wr_enabled)
    );

    // Command frame sequencer: opcode, address, data, then drain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= FR_OPCODE;
            op_q    <= '0;
            addr_q  <= '0;
        end else if (cs_hi) begin
            frame_q <= FR_OPCODE;
        end else if (byte_done) begin
            case (frame_q)
                FR_OPCODE: begin
                    op_q <= rx_byte;
                    if (rx_byte == OP_GET || rx_byte == OP_SET)
                        frame_q <= FR_ADDR;
                    else if (rx_byte == OP_WREN || rx_byte == OP_WRDIS)
                        frame_q <= FR_SINGLE;
                    else
                        frame_q <= FR_DRAIN;
                end
                FR_ADDR: begin
                    addr_q  <= rx_byte;
                    frame_q <= (op_q == OP_SET) ? FR_WDATA : FR_DRAIN;
                end
                default: frame_q <= FR_DRAIN;
            endcase
        end
    end

    // Read-data serializer: load after the address byte, shift on falling SCLK
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr    <= '0;
            tx_left  <= '0;
            spi_miso <= 1'b0;
        end else if (cs_hi) begin
            tx_left  <= '0;
            spi_miso <= 1'b0;
        end else if (byte_done && frame_q == FR_ADDR && op_q == OP_GET) begin
            tx_sr   <= rd_data;
            tx_left <= TXC_W'(BYTE_W);
        end else if (sck_fall) begin
            if (tx_left != '0) begin
                spi_miso <= tx_sr[BYTE_W-1];
                tx_sr    <= {tx_sr[BYTE_W-2:0], 1'b0};
                tx_left  <= tx_left - 1'b1;
            end else begin
                spi_miso <= 1'b0;
            end
        end
    end

    // R1: the data line is quiet while the part is deselected
    p_miso_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !spi_miso);
    // R4: the latch never moves in the middle of a selected frame
    p_wel_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_rise) |=> $stable(wr_enabled));
endmodule

// File: tb/nand_feat_resp_tb.sv
`timescale 1ns/1ps
// Bench: a vector table of commands and expected read values, then directed
// tests for the status load port, cancelled frames and reset.
module nand_feat_resp_tb;
    localparam int HALF = 8;   // clk cycles per SCLK phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       miso;
    logic       upd = 1'b0, busy = 1'b0, efail = 1'b0, pfail = 1'b0;
    logic [1:0] ecc = 2'b00;
    logic [7:0] lock, cfg;
    logic       wel;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nand_feat_resp u_dut (
        .clk (clk), .rst_n (rst_n),
        .spi_sck (sck), .spi_cs_n (cs_n), .spi_mosi (mosi), .spi_miso (miso),
        .ar_upd (upd), .ar_busy (busy), .ar_erase_fail (efail),
        .ar_prog_fail (pfail), .ar_ecc (ecc),
        .blk_lock (lock), .cfg_bits (cfg), .wr_enabled (wel)
    );

    // {opcode, address, write data, expected read}
    localparam logic [31:0] VEC [15] = '{
        {8'h0F, 8'hA0, 8'h00, 8'h38},  // R8 lock after reset
        {8'h0F, 8'hB0, 8'h00, 8'h10},  // R8 config after reset
        {8'h0F, 8'hC0, 8'h00, 8'h00},  // R8 status after reset
        {8'h1F, 8'hA0, 8'h00, 8'h00},  // R2 unlock all
        {8'h0F, 8'hA0, 8'h00, 8'h00},  // R2
        {8'h1F, 8'hB0, 8'hFF, 8'h00},  // R2 masked write
        {8'h0F, 8'hB0, 8'h00, 8'h51},  // R2
        {8'h1F, 8'hC0, 8'hFF, 8'h00},  // R3 ignored write
        {8'h0F, 8'hC0, 8'h00, 8'h00},  // R3
        {8'h06, 8'h00, 8'h00, 8'h00},  // R4 set latch
        {8'h0F, 8'hC0, 8'h00, 8'h02},  // R4 latch at bit 1
        {8'h04, 8'h00, 8'h00, 8'h00},  // R4 clear latch
        {8'h0F, 8'hC0, 8'h00, 8'h00},  // R4
        {8'h0F, 8'h55, 8'h00, 8'h00},  // R6 unknown address
        {8'h0F, 8'hC7, 8'h00, 8'h00}   // R6 unknown address
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // Clock out the top n bits of tx, capture MISO before each rising edge
    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    task automatic get_reg(input logic [7:0] a, output logic [7:0] v);
        logic [7:0] dummy;
        sel();
        spi_bits(8'h0F, 8, dummy);
        spi_bits(a, 8, dummy);
        spi_bits(8'h00, 8, v);
        desel();
    endtask

    task automatic set_reg(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        sel();
        spi_bits(8'h1F, 8, dummy);
        spi_bits(a, 8, dummy);
        spi_bits(d, 8, dummy);
        desel();
    endtask

    task automatic one_op(input logic [7:0] op);
        logic [7:0] dummy;
        sel();
        spi_bits(op, 8, dummy);
        desel();
    endtask

    task automatic load_status(input logic b, input logic e, input logic p, input logic [1:0] c);
        busy = b; efail = e; pfail = p; ecc = c;
        upd = 1'b1;
        wait_clk(1);
        upd = 1'b0;
        wait_clk(2);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        wait_clk(150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, dummy;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        check("R1 idle miso", {7'd0, miso}, 8'h00);
        check("R8 wel port", {7'd0, wel}, 8'h00);

        // Table walk
        for (int k = 0; k < 15; k++) begin
            logic [7:0] op, ad, wd, ex;
            {op, ad, wd, ex} = VEC[k];
            if (op == 8'h0F) begin
                get_reg(ad, v);
                check($sformatf("R1 vector %0d", k), v, ex);
            end else if (op == 8'h1F) begin
                set_reg(ad, wd);
            end else begin
                one_op(op);
            end
        end
        check("R2 lock port", lock, 8'h00);
        check("R2 cfg port", cfg, 8'h51);

        // R5: array model loads status fields
        load_status(1'b1, 1'b1, 1'b0, 2'b10);
        get_reg(8'hC0, v);
        check("R5 busy/erase/uncorrectable", v, 8'h25);
        load_status(1'b0, 1'b0, 1'b1, 2'b01);
        get_reg(8'hC0, v);
        check("R5 program fail/corrected", v, 8'h18);
        one_op(8'h06);
        get_reg(8'hC0, v);
        check("R3 status with latch", v, 8'h1A);
        set_reg(8'hC0, 8'h00);
        get_reg(8'hC0, v);
        check("R3 host write to status ignored", v, 8'h1A);
        one_op(8'h04);
        check("R4 latch cleared port", {7'd0, wel}, 8'h00);

        // R7: write data byte cut after 5 bits
        sel();
        spi_bits(8'h1F, 8, dummy);
        spi_bits(8'hA0, 8, dummy);
        spi_bits(8'hFF, 5, dummy);
        desel();
        get_reg(8'hA0, v);
        check("R7 partial write dropped", v, 8'h00);
        check("R7 lock port unchanged", lock, 8'h00);

        // R7/R4: write-enable followed by 3 stray bits
        sel();
        spi_bits(8'h06, 8, dummy);
        spi_bits(8'hFF, 3, dummy);
        desel();
        check("R4 stray bits cancel latch", {7'd0, wel}, 8'h00);
        get_reg(8'hC0, v);
        check("R7 status unchanged", v, 8'h18);

        // R6: unrecognised opcode shaped like a write
        sel();
        spi_bits(8'h9F, 8, dummy);
        spi_bits(8'hA0, 8, dummy);
        spi_bits(8'hFF, 8, dummy);
        desel();
        get_reg(8'hA0, v);
        check("R6 unknown opcode no effect", v, 8'h00);

        // R8: reset in the middle of operation
        one_op(8'h06);
        wait_clk(2);
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        check("R8 lock port", lock, 8'h38);
        check("R8 cfg port", cfg, 8'h10);
        check("R8 latch port", {7'd0, wel}, 8'h00);
        get_reg(8'hC0, v);
        check("R8 status read", v, 8'h00);
        get_reg(8'hB0, v);
        check("R8 config read", v, 8'h10);
        check("R1 miso after frame", {7'd0, miso}, 8'h00);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule